// File: doc/BRIEF.md
# Gated Multi-Encoding Clock Divider

This block turns a source clock into a slower peripheral clock. The source is either an oscillator clock or a PLL-derived clock. A glitch-free two-flop handshake switch chooses between them when the mux variant is built. A divisor field of parameter width `DIV_W`, together with a two-bit encoding code, sets the division ratio. An enable input gates the output.

Any change to the encoding, the divisor or the enable is taken at a period boundary, so the output never emits a shortened pulse. Even ratios give a 50% duty cycle. Odd ratios give a high phase one source cycle shorter than the low phase. A ratio of one passes the source clock through a latch-based gate. The encoding code 00 stops the output. The block is meant to sit next to a register file that drives its configuration pins.

Top module: `clkdiv_gated`

## Requirements
- R1: With encoding code 01 the output period is (divisor field + 1) source cycles.
- R2: With encoding code 10 the output period is 2 x (divisor field + 1) source cycles, with the output high for exactly half the period.
- R3: With encoding code 11 the output period is 2^(divisor field + 1) source cycles. Field values of DIV_W or more saturate at 2^(DIV_W+1).
- R4: With encoding code 00 the output is held low and has no rising edge.
- R5: Lowering enable_i lets the current output period complete with its full high phase. After that the output stays low.
- R6: For an odd ratio r > 1, the high phase lasts (r-1)/2 source cycles and the low phase lasts (r+1)/2 source cycles. For an even ratio r, each phase lasts r/2 source cycles.
- R7: A ratio of one (code 01, field 0) forwards the selected source clock itself: the output is high for half a source period and repeats every source period.
- R8: A divisor or encoding change made during a period does not affect that period. The new ratio applies from the next period onward.
- R9: src_sel_i = 0 divides the oscillator clock and src_sel_i = 1 divides the PLL clock. Only one source drives the divider at any time.
- R10: While rst_ni is low the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Oscillator reference clock |
| pll_clk_i | input | 1 | PLL-derived clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_sel_i | input | 1 | Source select: 0 oscillator, 1 PLL |
| enable_i | input | 1 | Output gate enable, asynchronous |
| enc_i | input | 2 | Divisor encoding: 00 off, 01 field+1, 10 2x(field+1), 11 power of two |
| div_val_i | input | DIV_W | Divisor field |
| clk_o | output | 1 | Divided, gated clock |

## Verification
The bench builds the block with DIV_W = 4 and the source mux present. A 4-bit field lets field values 4 and 5 under the power-of-two code reach the saturation limit of 32. The mux variant lets the same ratios be timed on both the 8-unit oscillator and the 6-unit PLL clock, including switches in both directions. Period and high-phase lengths are measured at the clk_o edges. This covers odd duty, the pass-through ratio of one, mid-period divisor changes and mid-pulse disable.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic [1:0] {
    ENC_OFF  = 2'b00,
    ENC_P1   = 2'b01,
    ENC_DBL  = 2'b10,
    ENC_POW2 = 2'b11
  } enc_e;
endpackage

// File: rtl/clkdiv_sync.sv
module clkdiv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/clkdiv_src_switch.sv
module clkdiv_src_switch #(
  parameter bit HAS_MUX = 1'b1
) (
  input  logic osc_clk_i,
  input  logic pll_clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  output logic mclk_o
);
  if (HAS_MUX) begin : g_mux
    logic osc_s1_q, osc_en_q, pll_s1_q, pll_en_q;

    // each side may only start once the other side's enable has dropped
    always_ff @(posedge osc_clk_i or negedge rst_ni) begin
      if (!rst_ni) osc_s1_q <= 1'b0;
      else         osc_s1_q <= !sel_i && !pll_en_q;
    end
    always_ff @(negedge osc_clk_i or negedge rst_ni) begin
      if (!rst_ni) osc_en_q <= 1'b0;
      else         osc_en_q <= osc_s1_q;
    end

    always_ff @(posedge pll_clk_i or negedge rst_ni) begin
      if (!rst_ni) pll_s1_q <= 1'b0;
      else         pll_s1_q <= sel_i && !osc_en_q;
    end
    always_ff @(negedge pll_clk_i or negedge rst_ni) begin
      if (!rst_ni) pll_en_q <= 1'b0;
      else         pll_en_q <= pll_s1_q;
    end

    assign mclk_o = (osc_clk_i && osc_en_q) || (pll_clk_i && pll_en_q);

    p_one_source_r9: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
      !(osc_en_q && pll_en_q));
  end else begin : g_nomux
    logic unused_pll;
    assign unused_pll = pll_clk_i ^ sel_i ^ rst_ni;
    assign mclk_o = osc_clk_i;
  end
endmodule

// File: rtl/clkdiv_ratio.sv
module clkdiv_ratio
  import clkdiv_pkg::*;
#(
  parameter int DIV_W = 4,
  localparam int CNT_W = DIV_W + 2,
  localparam int SH_W  = (DIV_W > 1) ? $clog2(DIV_W) : 1
) (
  input  enc_e             enc_i,
  input  logic [DIV_W-1:0] val_i,
  output logic [CNT_W-1:0] ratio_o
);
  logic [CNT_W-1:0] plus1;
  logic             pow_sat;

  assign plus1   = CNT_W'(val_i) + CNT_W'(1);
  assign pow_sat = val_i >= DIV_W'(DIV_W);

  always_comb begin
    unique case (enc_i)
      ENC_P1:   ratio_o = plus1;
      ENC_DBL:  ratio_o = plus1 << 1;
      ENC_POW2: ratio_o = pow_sat ? (CNT_W'(1) << (DIV_W + 1))
                                  : (CNT_W'(2) << val_i[SH_W-1:0]);
      default:  ratio_o = '0;
    endcase
  end
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
  import clkdiv_pkg::*;
#(
  parameter int DIV_W = 4,
  localparam int CNT_W = DIV_W + 2
) (
  input  logic             mclk_i,
  input  logic             rst_ni,
  input  logic             run_req_i,
  input  enc_e             enc_i,
  input  logic [DIV_W-1:0] val_i,
  output logic             clk_o
);
  logic [CNT_W-1:0] new_ratio, new_hi, cnt_q, cnt_inc, ratio_q, hi_q;
  logic new_run, new_byp, last, run_q, byp_q, div_q, byp_lat;

  clkdiv_ratio #(.DIV_W(DIV_W)) ratio_i (
    .enc_i  (enc_i),
    .val_i  (val_i),
    .ratio_o(new_ratio)
  );

  assign new_run = run_req_i && (new_ratio != '0);
  assign new_byp = new_ratio == CNT_W'(1);
  assign new_hi  = new_ratio >> 1;
  assign cnt_inc = cnt_q + CNT_W'(1);
  // config and enable are only taken at the end of a period or while idle
  assign last    = !run_q || (cnt_q == ratio_q - CNT_W'(1));

  always_ff @(posedge mclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= '0;
      hi_q    <= '0;
      run_q   <= 1'b0;
      byp_q   <= 1'b0;
      div_q   <= 1'b0;
    end else if (last) begin
      cnt_q   <= '0;
      ratio_q <= new_ratio;
      hi_q    <= new_hi;
      run_q   <= new_run;
      byp_q   <= new_byp;
      div_q   <= new_run && !new_byp && (new_hi != '0);
    end else begin
      cnt_q   <= cnt_inc;
      div_q   <= !byp_q && (cnt_inc < hi_q);
    end
  end

  // pass-through gate for ratio one: enable changes only while the clock is low
  always_latch begin
    if (!rst_ni)      byp_lat = 1'b0;
    else if (!mclk_i) byp_lat = run_q && byp_q;
  end

  assign clk_o = div_q || (mclk_i && byp_lat);

  p_cnt_in_range_r8: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q < ratio_q));
  p_cfg_hold_r8: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    (run_q && !last) |=> $stable(ratio_q) && $stable(hi_q));
  p_off_low_r4: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    !run_q |-> !div_q);
  p_start_at_zero_r5: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    $rose(run_q) |-> (cnt_q == '0));
  p_byp_ratio_r7: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    (run_q && byp_q) |-> (ratio_q == CNT_W'(1)) && !div_q);
endmodule

// File: rtl/clkdiv_gated.sv
module clkdiv_gated
  import clkdiv_pkg::*;
#(
  parameter int DIV_W   = 4,
  parameter bit HAS_MUX = 1'b1
) (
  input  logic             osc_clk_i,
  input  logic             pll_clk_i,
  input  logic             rst_ni,
  input  logic             src_sel_i,
  input  logic             enable_i,
  input  logic [1:0]       enc_i,
  input  logic [DIV_W-1:0] div_val_i,
  output logic             clk_o
);
  logic mclk, run_req;

  clkdiv_src_switch #(.HAS_MUX(HAS_MUX)) switch_i (
    .osc_clk_i(osc_clk_i),
    .pll_clk_i(pll_clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (src_sel_i),
    .mclk_o   (mclk)
  );

  clkdiv_sync #(.STAGES(2)) en_sync_i (
    .clk_i (mclk),
    .rst_ni(rst_ni),
    .d_i   (enable_i),
    .q_o   (run_req)
  );

  clkdiv_core #(.DIV_W(DIV_W)) core_i (
    .mclk_i   (mclk),
    .rst_ni   (rst_ni),
    .run_req_i(run_req),
    .enc_i    (enc_e'(enc_i)),
    .val_i    (div_val_i),
    .clk_o    (clk_o)
  );
endmodule

// File: tb/clkdiv_gated_tb_top.sv
module clkdiv_gated_tb_top;
  logic osc = 1'b0, pll = 1'b0, rst_n = 1'b0, sel = 1'b0, en = 1'b0;
  logic [1:0] enc = 2'b01;
  logic [3:0] val = 4'd3;
  logic clk_o;
  int n_chk = 0, n_fail = 0, edges = 0;

  always #4 osc = ~osc;  // 125 MHz reference (8 units)
  always #3 pll = ~pll;

  clkdiv_gated #(.DIV_W(4), .HAS_MUX(1'b1)) dut_i (
    .osc_clk_i(osc), .pll_clk_i(pll), .rst_ni(rst_n), .src_sel_i(sel),
    .enable_i(en), .enc_i(enc), .div_val_i(val), .clk_o(clk_o)
  );

  always @(posedge clk_o) edges++;

  // sel, enc, val, period, high, requirement
  localparam int TBL [12][6] = '{
    '{0, 1, 3,  32,  16, 1},  // R1 ratio 4
    '{0, 1, 2,  24,   8, 1},  // R1 R6 ratio 3
    '{0, 1, 4,  40,  16, 6},  // R6 ratio 5
    '{0, 2, 0,  16,   8, 2},  // R2 ratio 2
    '{0, 2, 2,  48,  24, 2},  // R2 ratio 6
    '{0, 3, 0,  16,   8, 3},  // R3 ratio 2
    '{0, 3, 2,  64,  32, 3},  // R3 ratio 8
    '{0, 3, 5, 256, 128, 3},  // R3 saturated at 32
    '{0, 1, 0,   8,   4, 7},  // R7 pass-through
    '{1, 2, 1,  24,  12, 9},  // R9 pll ratio 4
    '{1, 1, 2,  18,   6, 9},  // R9 pll ratio 3
    '{0, 3, 1,  32,  16, 9}   // R9 back to osc ratio 4
  };

  task automatic chk(input int req, input string what, input real act, input real exp);
    n_chk++;
    if (act > exp + 0.5 || act < exp - 0.5) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0.1f expected %0.1f", req, what, act, exp);
    end
  endtask

  task automatic measure(output real per, output real hi);
    real t0, t1, t2;
    @(posedge clk_o); @(posedge clk_o); @(posedge clk_o);
    t0 = $realtime;
    @(negedge clk_o); t1 = $realtime;
    @(posedge clk_o); t2 = $realtime;
    per = t2 - t0;
    hi  = t1 - t0;
  endtask

  initial begin
    #200000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    real per, hi, t0, t1;
    int e0;
    en = 1'b1;
    #21;
    chk(10, "clk_o in reset", real'(clk_o), 0.0);  // R10
    #2 rst_n = 1'b1;

    for (int i = 0; i < 12; i++) begin
      @(posedge clk_o); #1;
      sel = TBL[i][0] != 0;
      enc = 2'(TBL[i][1]);
      val = 4'(TBL[i][2]);
      measure(per, hi);
      chk(TBL[i][5], $sformatf("row %0d period", i), per, real'(TBL[i][3]));
      chk(TBL[i][5], $sformatf("row %0d high", i), hi, real'(TBL[i][4]));
    end

    // R8: change ratio 8 -> 2 in the middle of a high phase
    enc = 2'b01; val = 4'd7;
    measure(per, hi);
    chk(8, "ratio 8 settle period", per, 64.0);
    @(posedge clk_o); t0 = $realtime;
    #12 val = 4'd1;
    @(negedge clk_o); t1 = $realtime;
    chk(8, "high kept after change", t1 - t0, 32.0);
    @(posedge clk_o);
    chk(8, "old period kept", $realtime - t0, 64.0);
    measure(per, hi);
    chk(8, "new ratio 2 period", per, 16.0);

    // R5: disable mid-pulse, ratio 8
    val = 4'd7;
    measure(per, hi);
    @(posedge clk_o); t0 = $realtime;
    #12 en = 1'b0;
    @(negedge clk_o);
    chk(5, "final high phase", $realtime - t0, 32.0);
    #41 e0 = edges;
    #400;
    chk(5, "edges while disabled", real'(edges - e0), 0.0);

    // R4: encoding off
    en = 1'b1; enc = 2'b00;
    #300 e0 = edges;
    #400;
    chk(4, "edges with encoding off", real'(edges - e0), 0.0);
    chk(4, "clk_o level with encoding off", real'(clk_o), 0.0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule